// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Counter

The block measures how fast a target clock runs by counting its edges during a window timed by a reference clock. Software writes a window length in reference ticks and an enable bit into a control word. The reference domain then holds a gate open for exactly that many ticks. A two-flop synchronizer carries the gate into the target domain, where a counter clears on the gate's rising edge and counts while the gate is high.

When the gate closes, the reference domain waits until the synchronized gate returns low from the target domain and a short guard time has passed. It then captures the target count into the status word and raises a done flag. Software reads the count and then writes the enable bit clear, which stops the run and drops done. A new run can only start after that clear.

The target counter is cleared only by its own clock. If the target clock is stopped, a run reports the count of the previous run again. Software detects a dead clock by comparing two windows of different length.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset, the control word (offset 0) and the status word (offset 4) both read as zero.
- R2: The control word holds the window length in bits TICK_W-1:0 (19:0 by default) and the enable bit at bit TICK_W (bit 20). It reads back as written. Any address other than 0 and 4 reads zero.
- R3: A control write with enable set, made while the block is idle, starts a window of that many reference ticks, with zero treated as one. Done stays low until at least that many reference cycles after the write.
- R4: Done rises only after the gate has closed and the synchronized gate has returned low from the target domain. The count is the number of target edges in the window minus one, within ±2 of ticks·f_tgt/f_ref − 1.
- R5: The status word carries done at bit CNT_W (bit 25) and the count in bits CNT_W-1:0 (24:0). All higher bits read zero.
- R6: A control write with enable clear stops the run and drops done at the same clock edge. If it lands inside a window, done stays low afterwards.
- R7: While done is high, a control write with enable set starts nothing. Done stays high and the count is unchanged.
- R8: The reported count holds steady for as long as done is high.
- R9: The target count saturates at all ones instead of wrapping.
- R10: With the target clock stopped, a new run reports the previous count unchanged.
- R11: When a clearing write lands in the same cycle in which the run would complete, the clear wins and done stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock; the register port runs on it |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| tgt_clk_i | input | 1 | Clock being measured |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address: 0 is control, 4 is status |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for addr_i |

## Verification
The completion of a run and a clearing control write can land in the same reference cycle. In that cycle the clear must win, and done must not flash high afterwards. The bench starts a short window against a fast target clock and then sweeps the clearing write across every cycle offset from before the gate closes to after the expected completion. After each clear it checks done on the next cycle and again much later. A per-cycle model flags done whenever no run could legitimately have finished.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int CTRL_OFS = 0;
  localparam int STAT_OFS = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_DONE
  } fm_state_e;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fm_regs.sv
module fm_regs #(
  parameter int TICK_W = 20,
  parameter int CNT_W  = 25,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic              cap_i,
  input  logic [CNT_W-1:0]  tgt_cnt_i,
  output logic              en_o,
  output logic [TICK_W-1:0] ticks_o,
  output logic              clr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int EN_BIT   = TICK_W;
  localparam int DONE_BIT = CNT_W;

  logic              en_q;
  logic [TICK_W-1:0] ticks_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_ctrl;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(fm_pkg::CTRL_OFS));
  assign clr_o   = wr_ctrl && !wdata_i[EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      ticks_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= wdata_i[EN_BIT];
        ticks_q <= wdata_i[TICK_W-1:0];
      end
      // target count is frozen while captured (gate closed, ack returned)
      if (cap_i) cnt_q <= tgt_cnt_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(fm_pkg::CTRL_OFS)) begin
      rdata_o[TICK_W-1:0] = ticks_q;
      rdata_o[EN_BIT]     = en_q;
    end else if (addr_i == ADDR_W'(fm_pkg::STAT_OFS)) begin
      rdata_o[CNT_W-1:0] = cnt_q;
      rdata_o[DONE_BIT]  = done_i;
    end
  end

  assign en_o    = en_q;
  assign ticks_o = ticks_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/fm_ref_ctrl.sv
module fm_ref_ctrl #(
  parameter int TICK_W = 20,
  parameter int GUARD  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [TICK_W-1:0] ticks_i,
  input  logic              clr_i,
  input  logic              ack_i,
  output logic              gate_o,
  output logic              done_o,
  output logic              cap_o
);
  import fm_pkg::*;

  localparam int GW = $clog2(GUARD + 1);

  fm_state_e         state_q;
  logic [TICK_W-1:0] win_q;
  logic [GW-1:0]     grd_q;
  logic              gate_q;
  logic              done_q;
  logic              drain_ok;

  assign drain_ok = (grd_q == GW'(GUARD)) && !ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      grd_q   <= '0;
      gate_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
      gate_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (en_i && !ack_i) begin
          state_q <= ST_RUN;
          gate_q  <= 1'b1;
          win_q   <= (ticks_i == '0) ? TICK_W'(1) : ticks_i;
        end
        ST_RUN: begin
          if (win_q <= TICK_W'(1)) begin
            state_q <= ST_DRAIN;
            gate_q  <= 1'b0;
            grd_q   <= '0;
          end else begin
            win_q <= win_q - 1'b1;
          end
        end
        ST_DRAIN: begin
          if (drain_ok) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
          end else if (grd_q != GW'(GUARD)) begin
            grd_q <= grd_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign gate_o = gate_q;
  assign done_o = done_q;
  assign cap_o  = (state_q == ST_DRAIN) && drain_ok && !clr_i;
endmodule

// File: rtl/fm_tgt_cnt.sv
module fm_tgt_cnt #(
  parameter int CNT_W = 25
) (
  input  logic             tgt_clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             gate_s_o
);
  logic             gate_s;
  logic             gate_d_q;
  logic [CNT_W-1:0] cnt_q;

  fm_sync #(.W(1), .STAGES(2)) u_gate_sync (
    .clk_i (tgt_clk_i),
    .rst_ni(rst_ni),
    .d_i   (gate_i),
    .q_o   (gate_s)
  );

  always_ff @(posedge tgt_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_d_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      gate_d_q <= gate_s;
      if (gate_s && !gate_d_q)             cnt_q <= '0;
      else if (gate_s && cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign gate_s_o = gate_s;
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter #(
  parameter int TICK_W = 20,
  parameter int CNT_W  = 25,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int GUARD  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tgt_clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              en_w;
  logic [TICK_W-1:0] ticks_w;
  logic              clr_w;
  logic              gate_w;
  logic              done_w;
  logic              cap_w;
  logic              ack_s_w;
  logic              tgt_gate_s_w;
  logic [CNT_W-1:0]  tgt_cnt_w;
  logic [CNT_W-1:0]  cap_cnt_w;

  fm_regs #(
    .TICK_W(TICK_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .done_i   (done_w),
    .cap_i    (cap_w),
    .tgt_cnt_i(tgt_cnt_w),
    .en_o     (en_w),
    .ticks_o  (ticks_w),
    .clr_o    (clr_w),
    .cnt_o    (cap_cnt_w),
    .rdata_o  (rdata_o)
  );

  fm_ref_ctrl #(.TICK_W(TICK_W), .GUARD(GUARD)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_w),
    .ticks_i(ticks_w),
    .clr_i  (clr_w),
    .ack_i  (ack_s_w),
    .gate_o (gate_w),
    .done_o (done_w),
    .cap_o  (cap_w)
  );

  fm_tgt_cnt #(.CNT_W(CNT_W)) u_tgt (
    .tgt_clk_i(tgt_clk_i),
    .rst_ni   (rst_ni),
    .gate_i   (gate_w),
    .cnt_o    (tgt_cnt_w),
    .gate_s_o (tgt_gate_s_w)
  );

  fm_sync #(.W(1), .STAGES(2)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tgt_gate_s_w),
    .q_o   (ack_s_w)
  );
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int TICK_W = 20,
  parameter int CNT_W  = 25,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tgt_clk_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              gate_i,
  input logic              done_i,
  input logic              ack_i,
  input logic [CNT_W-1:0]  cap_cnt_i,
  input logic [CNT_W-1:0]  tgt_cnt_i,
  input logic              tgt_gate_s_i
);
  logic clr_wr;
  assign clr_wr = wr_en_i && (addr_i == ADDR_W'(fm_pkg::CTRL_OFS)) && !wdata_i[TICK_W];

  // R4: done only with the gate closed
  a_r4_done_gate_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !gate_i);

  // R4: done rises only once the returned gate is low
  a_r4_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> !ack_i);

  // R6 / R11: a clearing write drops done and gate next cycle
  a_r6_clear_drops_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> (!done_i && !gate_i));

  // R8: count held while done
  a_r8_count_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> $stable(cap_cnt_i));

  // R9: saturation at all ones
  a_r9_no_wrap: assert property (@(posedge tgt_clk_i) disable iff (!rst_ni)
    ((&tgt_cnt_i) && tgt_gate_s_i && $past(tgt_gate_s_i)) |=> (&tgt_cnt_i));
endmodule

bind clk_freq_meter fm_checker #(
  .TICK_W(TICK_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tgt_clk_i   (tgt_clk_i),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .gate_i      (gate_w),
  .done_i      (done_w),
  .ack_i       (ack_s_w),
  .cap_cnt_i   (cap_cnt_w),
  .tgt_cnt_i   (tgt_cnt_w),
  .tgt_gate_s_i(tgt_gate_s_w)
);

// File: tb/clk_freq_meter_tb_top.sv
`timescale 1ns/1ps
module clk_freq_meter_tb_top;
  localparam int LIMIT = 150000;
  localparam logic [31:0] EN = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        tgt_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] rdata_sat;

  integer tests = 0, fails = 0, cyc = 0;
  integer tgt_half = 5;
  bit     tgt_run = 1'b1;

  // behavioural model state
  integer m_phase = 0, m_start = 0, m_len = 0;
  bit     prev_done = 1'b0;
  logic [24:0] prev_cnt = '0;

  always #10 clk = ~clk;
  always begin
    #(tgt_half);
    if (tgt_run) tgt_clk = ~tgt_clk;
  end

  clk_freq_meter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tgt_clk_i(tgt_clk),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  clk_freq_meter #(.CNT_W(6)) dut_sat_i (
    .clk_i(clk), .rst_ni(rst_n), .tgt_clk_i(tgt_clk),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_sat)
  );

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_n && wr_en && addr == 4'd0) begin
      if (!wdata[20]) m_phase = 0;
      else if (m_phase == 0) begin
        m_phase = 1;
        m_start = cyc;
        m_len   = (wdata[19:0] == 0) ? 1 : int'(wdata[19:0]);
      end
    end
    if (cyc == LIMIT) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      finish_run();
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #5;
    if (rst_n && !wr_en && addr == 4'd4) begin
      tests++;
      if (rdata[25] && !(m_phase == 1 && cyc >= m_start + m_len + 1)) begin
        fails++;
        $display("FAIL R3 early done actual=1 expected=0 cyc=%0d", cyc);
      end
      if (rdata[25] && prev_done && rdata[24:0] != prev_cnt) begin
        fails++;
        $display("FAIL R8 count moved actual=%0d expected=%0d", rdata[24:0], prev_cnt);
      end
      prev_done = rdata[25];
      prev_cnt  = rdata[24:0];
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 4'd4;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #6 v = rdata;
    addr = 4'd4;
  endtask

  task automatic wait_done(input integer maxc, output integer took);
    took = 0;
    while (took < maxc) begin
      @(negedge clk); #6;
      took++;
      if (rdata[25]) break;
    end
  endtask

  function automatic bit near(input longint a, input longint e);
    return (a >= e - 2) && (a <= e + 2);
  endfunction

  initial begin
    logic [31:0] v;
    integer took;
    logic [24:0] c1;

    repeat (3) @(negedge clk);
    #6;
    chk(rdata == 0, "R1 status reset", rdata, 0);
    rst_n = 1'b1;
    rd(4'd0, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd(4'd4, v); chk(v == 0, "R1 status reset", v, 0);

    // R2 layout and readback
    wr(4'd0, 32'd100);
    rd(4'd0, v); chk(v == 32'd100, "R2 ctrl readback", v, 100);
    rd(4'd8, v); chk(v == 0, "R2 unmapped", v, 0);
    rd(4'd4, v); chk(v[25] == 1'b0, "R6 idle done low", v[25], 0);

    // R3 / R4 / R9 : fast target, ratio 2
    tgt_half = 5;
    wr(4'd0, EN | 32'd100);
    rd(4'd0, v); chk(v == (EN | 32'd100), "R2 enable bit 20", v, EN | 32'd100);
    wait_done(1000, took);
    chk(took >= 100, "R3 window length", took, 100);
    rd(4'd4, v);
    chk(v[25] == 1'b1, "R4 done", v[25], 1);
    chk(near(v[24:0], 199), "R4 count ratio 2", v[24:0], 199);
    c1 = v[24:0];
    @(negedge clk); #6;
    chk(rdata_sat == 32'd127, "R9 saturate", rdata_sat, 127);

    // R7 relaunch while done is ignored
    wr(4'd0, EN | 32'd300);
    repeat (5) @(negedge clk);
    rd(4'd4, v);
    chk(v[25] == 1'b1, "R7 done held", v[25], 1);
    chk(v[24:0] == c1, "R7 count held", v[24:0], c1);

    // R6 clear drops done at once
    wr(4'd0, 32'd0);
    #6; chk(rdata[25] == 1'b0, "R6 clear", rdata[25], 0);

    // R10 stopped target repeats count
    repeat (20) @(negedge clk);
    tgt_run = 1'b0;
    wr(4'd0, EN | 32'd50);
    wait_done(500, took);
    rd(4'd4, v);
    chk(v[25] == 1'b1, "R10 done with stopped clock", v[25], 1);
    chk(v[24:0] == c1, "R10 stale count", v[24:0], c1);
    wr(4'd0, 32'd0);
    tgt_run = 1'b1;

    // R4 / R5 slow target, ratio 1/2, long window
    tgt_half = 20;
    repeat (20) @(negedge clk);
    wr(4'd0, EN | 32'h1000);
    wait_done(6000, took);
    rd(4'd4, v);
    chk(v[31:26] == 0 && v[25] == 1'b1, "R5 status layout", v[31:25], 1);
    chk(near(v[24:0], 2047), "R4 count ratio 1/2", v[24:0], 2047);
    wr(4'd0, 32'd0);

    // R3 zero ticks treated as one
    tgt_half = 5;
    repeat (20) @(negedge clk);
    wr(4'd0, EN);
    wait_done(200, took);
    chk(rdata[25] == 1'b1, "R3 zero ticks completes", rdata[25], 1);
    wr(4'd0, 32'd0);

    // R6 abort mid-window
    repeat (20) @(negedge clk);
    wr(4'd0, EN | 32'd1000);
    repeat (50) @(negedge clk);
    wr(4'd0, 32'd0);
    repeat (1200) @(negedge clk);
    #6; chk(rdata[25] == 1'b0, "R6 abort leaves done low", rdata[25], 0);

    // R11 clear swept across the completion cycle
    for (int off = 8; off <= 24; off++) begin
      repeat (30) @(negedge clk);
      wr(4'd0, EN | 32'd10);
      repeat (off) @(negedge clk);
      wr(4'd0, 32'd0);
      #6; chk(rdata[25] == 1'b0, "R11 clear wins", rdata[25], 0);
      repeat (30) @(negedge clk);
      #6; chk(rdata[25] == 1'b0, "R11 stays low", rdata[25], 0);
    end

    finish_run();
  end
endmodule